// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block tracks how trustworthy a CAN node currently is on the bus. It keeps an 8-bit transmit error counter and an 8-bit receive error counter, and derives from them a three-way confinement state: error active, error passive or bus off. The block only consumes one-cycle event pulses from the protocol engine. These are a transmit error, a receive error, a good transmission, a good reception, and one pulse for each run of eleven recessive bits seen on the bus. It does no error detection and no bit timing.

While the node is bus off, the block raises a transmit-disable output and ignores all error and success events. It counts recessive-run pulses and lets the node back onto the bus only after 128 of them. The block also marks the cycle in which the node drops off the bus, and every cycle in which the confinement state changes, with one-cycle pulses.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, the state reads 00 (error active), and `tx_block_o`, `busoff_evt_o` and `state_chg_o` are all 0.
- R2: Outside bus off, a transmit error adds 8 to the transmit counter and a good transmission subtracts 1 from it, never going below 0. When both arrive in the same cycle, the error wins. The new value shows at the ports one clock after the pulse.
- R3: Outside bus off, a receive error adds 1 to the receive counter only while the counter is 127 or less, so the counter never exceeds 128. A good reception subtracts 1, never going below 0. When both arrive in the same cycle, the error wins.
- R4: A good reception while the receive counter is 128 reloads that counter to 120.
- R5: Outside bus off, the state becomes 01 (error passive) in the same cycle that either counter shows 128 or more.
- R6: In error passive, the state returns to 00 only once both counters are below 127. With a counter at exactly 127 the state stays 01.
- R7: A transmit error while the transmit counter is 248 or more (its sum would pass 255) puts the node into bus off. From the next clock, the state reads 10, both counters read 0 and `tx_block_o` is 1.
- R8: While bus off, error and success pulses leave both counters at 0. Outside bus off, recessive-run pulses have no effect on the counters or the state.
- R9: Bus off ends at the 128th recessive-run pulse counted since entry. After the 127th pulse the state still reads 10. One clock after the 128th pulse it reads 00 with both counters at 0.
- R10: `busoff_evt_o` is high for exactly one cycle: the first cycle in which the state reads 10.
- R11: `state_chg_o` is high for exactly one cycle in each cycle whose state differs from the state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error pulse |
| rx_err_i | input | 1 | Receive error pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| idle_run_i | input | 1 | One pulse per detected run of 11 recessive bits |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| fc_state_o | output | 2 | Confinement state: 00 active, 01 passive, 10 bus off |
| tx_block_o | output | 1 | High while bus off; transmission forbidden |
| busoff_evt_o | output | 1 | One-cycle pulse on bus-off entry |
| state_chg_o | output | 1 | One-cycle pulse on any state change |

## Verification
Both counters are visible at the ports, so a wrong increment, decrement, reload or floor shows up in the very next cycle. A wrong state decision also shows up one clock after the event that should have caused it. The recovery counter is the only hidden state. An off-by-one in it shows only at the end of the 128-pulse recovery window, as a state change one pulse early or one pulse late, so the bench checks the state on both sides of that boundary. A long stretch of mixed random events is compared cycle by cycle against an arithmetic model. That run crosses the passive and bus-off thresholds many times, so a stale or skipped transition appears within a few events of the cycle where the model and the design first disagree.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  // decrement with a floor at zero
  function automatic int floor_dec(input int v);
    return (v > 0) ? v - 1 : 0;
  endfunction

  // either counter at or beyond the passive threshold
  function automatic logic hits_passive(input int tec, input int rec, input int lim);
    return (tec >= lim) || (rec >= lim);
  endfunction

  // both counters strictly below (threshold - 1)
  function automatic logic may_go_active(input int tec, input int rec, input int lim);
    return (tec < lim - 1) && (rec < lim - 1);
  endfunction

endpackage

// File: rtl/can_fc_txcnt.sv
module can_fc_txcnt #(
  parameter int CNT_W    = 8,
  parameter int ERR_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             ovf_o
);
  import can_fc_pkg::*;

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  int               cur;

  assign cur   = int'(cnt_q);
  assign ovf_o = !hold_i && err_i && (cur + ERR_STEP > CNT_MAX);

  always_comb begin
    if (hold_i || ovf_o)
      cnt_next_o = '0;
    else if (err_i)
      cnt_next_o = CNT_W'(cur + ERR_STEP);
    else if (ok_i)
      cnt_next_o = CNT_W'(floor_dec(cur));
    else
      cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;

  p_tec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !hold_i && !ovf_o) |=> int'(cnt_o) == int'($past(cnt_o)) + ERR_STEP);

  p_tec_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && !err_i && !hold_i && cnt_o != '0) |=> int'(cnt_o) == int'($past(cnt_o)) - 1);

  p_tec_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> cnt_o == '0);

endmodule

// File: rtl/can_fc_rxcnt.sv
module can_fc_rxcnt #(
  parameter int CNT_W       = 8,
  parameter int ERR_STEP    = 1,
  parameter int PASSIVE_LIM = 128,
  parameter int RELOAD      = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  import can_fc_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  int               cur;
  logic             reload_evt;

  assign cur        = int'(cnt_q);
  assign reload_evt = !clr_i && !err_i && ok_i && (cur >= PASSIVE_LIM);

  always_comb begin
    if (clr_i)
      cnt_next_o = '0;
    else if (err_i)
      cnt_next_o = (cur < PASSIVE_LIM) ? CNT_W'(cur + ERR_STEP) : cnt_q;
    else if (reload_evt)
      cnt_next_o = CNT_W'(RELOAD);
    else if (ok_i)
      cnt_next_o = CNT_W'(floor_dec(cur));
    else
      cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;

  p_rec_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_o) <= PASSIVE_LIM + ERR_STEP - 1);

  p_rec_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> int'(cnt_o) == RELOAD);

endmodule

// File: rtl/can_fc_recov.sv
module can_fc_recov #(
  parameter int RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic active_i,
  input  logic run_i,
  output logic done_o
);
  localparam int RW = (RUNS > 1) ? $clog2(RUNS) : 1;

  logic [RW-1:0] runs_q;

  assign done_o = active_i && run_i && (int'(runs_q) == RUNS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      runs_q <= '0;
    else if (arm_i || done_o)
      runs_q <= '0;
    else if (active_i && run_i)
      runs_q <= runs_q + 1'b1;
  end

  p_recov_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> runs_q == '0);

  p_recov_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !arm_i) |=> $stable(runs_q));

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W       = 8,
  parameter int TX_ERR_STEP = 8,
  parameter int RX_ERR_STEP = 1,
  parameter int PASSIVE_LIM = 128,
  parameter int RX_RELOAD   = 120,
  parameter int RECOV_RUNS  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             idle_run_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       fc_state_o,
  output logic             tx_block_o,
  output logic             busoff_evt_o,
  output logic             state_chg_o
);
  import can_fc_pkg::*;

  fc_state_e        state_q, state_d;
  logic             in_busoff;
  logic             tx_ovf;
  logic             rx_clr;
  logic             recov_done;
  logic [CNT_W-1:0] tec_next, rec_next;
  logic             evt_q, chg_q;

  assign in_busoff = (state_q == FC_BUSOFF);
  assign rx_clr    = in_busoff || tx_ovf;

  can_fc_txcnt #(.CNT_W(CNT_W), .ERR_STEP(TX_ERR_STEP)) u_tx (
    .clk(clk), .rst_n(rst_n), .hold_i(in_busoff), .err_i(tx_err_i), .ok_i(tx_ok_i),
    .cnt_o(tec_o), .cnt_next_o(tec_next), .ovf_o(tx_ovf)
  );

  can_fc_rxcnt #(.CNT_W(CNT_W), .ERR_STEP(RX_ERR_STEP), .PASSIVE_LIM(PASSIVE_LIM),
                 .RELOAD(RX_RELOAD)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .err_i(rx_err_i), .ok_i(rx_ok_i),
    .cnt_o(rec_o), .cnt_next_o(rec_next)
  );

  can_fc_recov #(.RUNS(RECOV_RUNS)) u_recov (
    .clk(clk), .rst_n(rst_n), .arm_i(tx_ovf), .active_i(in_busoff), .run_i(idle_run_i),
    .done_o(recov_done)
  );

  always_comb begin
    state_d = state_q;
    if (in_busoff) begin
      if (recov_done) state_d = FC_ACTIVE;
    end else if (tx_ovf) begin
      state_d = FC_BUSOFF;
    end else if (hits_passive(int'(tec_next), int'(rec_next), PASSIVE_LIM)) begin
      state_d = FC_PASSIVE;
    end else if (state_q == FC_PASSIVE &&
                 may_go_active(int'(tec_next), int'(rec_next), PASSIVE_LIM)) begin
      state_d = FC_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FC_ACTIVE;
      evt_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= tx_ovf;
      chg_q   <= (state_d != state_q);
    end
  end

  assign fc_state_o   = state_q;
  assign tx_block_o   = in_busoff;
  assign busoff_evt_o = evt_q;
  assign state_chg_o  = chg_q;

  p_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_block_o && (int'(tec_o) >= PASSIVE_LIM || int'(rec_o) >= PASSIVE_LIM))
      |-> fc_state_o == 2'b01);

  p_active_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o == 2'b00) |-> (int'(tec_o) < PASSIVE_LIM && int'(rec_o) < PASSIVE_LIM));

  p_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> (tx_block_o && busoff_evt_o));

  p_busoff_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_block_o |-> (tec_o == '0 && rec_o == '0));

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> (fc_state_o == 2'b00 && state_chg_o));

  p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt_o |=> !busoff_evt_o);

  p_chg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg_o |-> fc_state_o != $past(fc_state_o));

endmodule

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err, rx_err, tx_ok, rx_ok, idle_run;
  logic [7:0] tec, rec;
  logic [1:0] st;
  logic tx_block, busoff_evt, st_chg;

  int checks = 0;
  int bad = 0;
  int m_tec = 0, m_rec = 0, m_st = 0, m_runs = 0;
  int e_evt = 0, e_chg = 0;

  always #(CLK_P/2) clk = ~clk;

  can_fault_conf u_can_fault_conf (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok),
    .rx_ok_i(rx_ok), .idle_run_i(idle_run), .tec_o(tec), .rec_o(rec), .fc_state_o(st),
    .tx_block_o(tx_block), .busoff_evt_o(busoff_evt), .state_chg_o(st_chg)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // arithmetic restatement of the rules, in the bench's own terms
  task automatic model(input logic txe, rxe, txo, rxo, idl);
    int prev;
    prev  = m_st;
    e_evt = 0;
    if (m_st == 2) begin
      if (idl) begin
        m_runs++;
        if (m_runs == 128) begin m_st = 0; m_runs = 0; end
      end
    end else begin
      if (txe) begin
        if (m_tec + 8 >= 256) begin
          m_st = 2; m_tec = 0; m_rec = 0; m_runs = 0; e_evt = 1;
        end else m_tec += 8;
      end else if (txo && m_tec > 0) m_tec--;
      if (m_st != 2) begin
        if (rxe) begin
          if (m_rec <= 127) m_rec++;
        end else if (rxo) begin
          if (m_rec >= 128) m_rec = 120;
          else if (m_rec > 0) m_rec--;
        end
        if (m_tec >= 128 || m_rec >= 128) m_st = 1;
        else if (m_st == 1 && m_tec <= 126 && m_rec <= 126) m_st = 0;
      end
    end
    e_chg = (m_st != prev) ? 1 : 0;
  endtask

  task automatic step(input logic txe, rxe, txo, rxo, idl);
    tx_err = txe; rx_err = rxe; tx_ok = txo; rx_ok = rxo; idle_run = idl;
    @(posedge clk);
    @(negedge clk);
    model(txe, rxe, txo, rxo, idl);
    chk("R2",  "tec",        int'(tec),        m_tec);
    chk("R3",  "rec",        int'(rec),        m_rec);
    chk("R5",  "state",      int'(st),         m_st);
    chk("R7",  "tx_block",   int'(tx_block),   (m_st == 2) ? 1 : 0);
    chk("R10", "busoff_evt", int'(busoff_evt), e_evt);
    chk("R11", "state_chg",  int'(st_chg),     e_chg);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_run = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tec", int'(tec), 0);
    chk("R1", "rec", int'(rec), 0);
    chk("R1", "state", int'(st), 0);
    chk("R1", "outputs", int'({tx_block, busoff_evt, st_chg}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: climb to the passive threshold with transmit errors
    for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0);
    chk("R5", "state at tec 120", int'(st), 0);
    step(1, 0, 0, 0, 0);
    chk("R5", "state at tec 128", int'(st), 1);

    // R6: hysteresis at 127
    step(0, 0, 1, 0, 0);
    chk("R6", "state at tec 127", int'(st), 1);
    step(0, 0, 1, 0, 0);
    chk("R6", "state at tec 126", int'(st), 0);

    // R8: recessive runs outside bus off change nothing
    step(0, 0, 0, 0, 1);
    chk("R8", "tec after idle run", int'(tec), 126);
    chk("R8", "state after idle run", int'(st), 0);

    for (int i = 0; i < 130; i++) step(0, 0, 1, 0, 0);
    chk("R2", "tec floor", int'(tec), 0);

    // R3 / R4: receive counter saturation and reload
    for (int i = 0; i < 128; i++) step(0, 1, 0, 0, 0);
    chk("R5", "state at rec 128", int'(st), 1);
    step(0, 1, 0, 0, 0);
    chk("R3", "rec held at 128", int'(rec), 128);
    step(0, 0, 0, 1, 0);
    chk("R4", "rec reload", int'(rec), 120);
    chk("R4", "state after reload", int'(st), 0);
    for (int i = 0; i < 125; i++) step(0, 0, 0, 1, 0);
    chk("R3", "rec floor", int'(rec), 0);

    // R7: bus off entry
    for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 0);
    chk("R7", "tec at 248", int'(tec), 248);
    step(1, 1, 0, 0, 0);
    chk("R7", "state bus off", int'(st), 2);
    chk("R10", "entry pulse", int'(busoff_evt), 1);

    // R8: events ignored during bus off
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    chk("R8", "tec in bus off", int'(tec), 0);
    chk("R8", "rec in bus off", int'(rec), 0);

    // R9: recovery after exactly 128 runs
    for (int i = 0; i < 127; i++) step(0, 0, 0, 0, 1);
    chk("R9", "state after 127 runs", int'(st), 2);
    step(0, 0, 0, 0, 1);
    chk("R9", "state after 128 runs", int'(st), 0);
    chk("R11", "change pulse on recovery", int'(st_chg), 1);

    // mixed random events against the model
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom_range(0, 1023));
      step(r[2:0] == 3'd0, r[4:3] == 2'd0, r[5], r[7:6] == 2'd0, r[8]);
    end

    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_run = 0;
    finish_run();
  end
endmodule